// File: doc/BRIEF.md
# Dynamic Dataflow Token Matching Unit

This block is the rendezvous point of a tagged-token dataflow pipeline. Each arriving token names a destination instruction, an operand port, an activity name and a data value. The activity name is a context number, an iteration number and a count of how many names are nested in the tag. The unit holds the tokens that are still waiting for partners in a small associative store. When the last missing operand of an activity arrives, the unit sends the whole operand set downstream as one packet.

A per-instruction table supplies two numbers: how many operands enable the instruction, and how many of those are constants held with the instruction. Constants count toward completion but never travel as tokens. A token that completes its instruction on its own, or together with that instruction's constants, goes straight to the output and never takes a store entry. When the store has no free entry, a token that needs one is held back through the input handshake and a stall flag is raised. A token that lands on a port already filled within its set is treated as a fatal program error, and the unit stops accepting input until reset.

Top module: `tmu_match_unit`

## Requirements
- R1: After a synchronous active-low reset, `pkt_valid`, `halted` and `store_stall` are 0, the store is empty (`tok_ready` is 1), and every table entry reads enable count 1 with constant count 0.
- R2: Two tokens join the same set only when the destination address, the context number, the iteration number and the name count are all equal. A token that differs in any one of these starts a separate set.
- R3: A set completes when the number of tokens in it plus the instruction's constant count reaches the enable count. Its packet appears on the cycle after the completing token is accepted, and its store entry is freed and can be reused by a later token.
- R4: A token whose instruction needs at most one token beyond its constants produces a packet on the cycle after acceptance. That packet holds only that token's slot, and the token takes no store entry.
- R5: In a packet, slot p of `pkt_data` (bits p*DW and up) carries the value that arrived on port p, and bit p of `pkt_mask` is set exactly for the ports that arrived. Absent slots read zero.
- R6: A token whose name count differs from a waiting entry's name count never joins that entry, even when its context and iteration numbers are the same.
- R7: A token whose port is already filled in the set it matches produces no packet. It sets `halted` from the next cycle on, and `tok_ready` then stays 0 until reset.
- R8: When every store entry is in use, a token that would need a new entry sees `tok_ready` at 0 and `store_stall` at 1. Tokens that match a waiting entry, and single-token instructions, are still accepted.
- R9: A table write changes the enable count and constant count used for tokens accepted on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | AW | Instruction address written |
| cfg_need | input | CW | Enable count (tokens plus constants) |
| cfg_const | input | CW | Constant operand count |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token accepted this cycle when high with tok_valid |
| tok_addr | input | AW | Destination instruction address |
| tok_port | input | PW | Operand port, below PORTS |
| tok_ctx | input | CTXW | Context number |
| tok_iter | input | ITW | Iteration number |
| tok_names | input | NW | Number of activity names in the tag |
| tok_data | input | DW | Operand value |
| pkt_valid | output | 1 | Packet present for one cycle |
| pkt_addr | output | AW | Instruction address of the packet |
| pkt_ctx | output | CTXW | Context number of the packet |
| pkt_iter | output | ITW | Iteration number of the packet |
| pkt_mask | output | PORTS | Ports present in the packet |
| pkt_data | output | PORTS*DW | Operand values, one DW slot per port |
| store_stall | output | 1 | A token is held back because the store is full |
| halted | output | 1 | Duplicate-port error seen; input closed |

## Verification
The bench builds the unit with ENTRIES=4, PORTS=4, AW=4, 8-bit context and iteration fields and DW=16. Four entries let four waiting three-operand sets fill the store, so the full-store stall can be reached and then released by completing one set. Four ports leave room for a three-token set and for an instruction that mixes one constant with two tokens. The 4-bit table address covers enough instructions to give single-token, constant-assisted, two-token and three-token instructions their own table entries at the same time.

// File: rtl/tmu_pkg.sv
// Shared types of the token matching unit.
// Assumes nothing beyond standard SystemVerilog.
package tmu_pkg;

    // Route chosen for the token at the input this cycle.
    typedef enum logic [1:0] {
        DISP_BYPASS = 2'd0,  // completes alone, skips the store
        DISP_MERGE  = 2'd1,  // joins a waiting entry
        DISP_ALLOC  = 2'd2,  // opens a fresh entry
        DISP_STALL  = 2'd3   // needs an entry, none free
    } disp_e;

endpackage

// File: rtl/tmu_cfg_table.sv
// Per-instruction enable table: for each instruction address it holds the
// operand count that enables the instruction and how many of those operands
// are constants. One synchronous write port and one combinational read port.
// Assumes: a written constant count is below the written enable count,
// or equal to it minus one for single-token instructions.
module tmu_cfg_table #(
    parameter int AW = 4,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_need,
    input  logic [CW-1:0] wr_const,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_need,
    output logic [CW-1:0] rd_const
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][CW-1:0] need_q;
    logic [DEPTH-1:0][CW-1:0] const_q;

    // Table storage: reset to "one token, no constants", then software-free writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                need_q[i]  <= CW'(1);
                const_q[i] <= '0;
            end
        end else if (wr_en) begin
            need_q[wr_addr]  <= wr_need;
            const_q[wr_addr] <= wr_const;
        end
    end

    // Lookup for the token at the input.
    always_comb begin
        rd_need  = need_q[rd_addr];
        rd_const = const_q[rd_addr];
    end
endmodule

// File: rtl/tmu_cam_search.sv
// One-cycle associative search over all store entries. A cheap first stage
// compares address and name count; only entries passing it have their
// context and iteration fields taken into the hit. Also finds the lowest
// free entry. Assumes: at most one entry holds any given full tag.
module tmu_cam_search #(
    parameter  int ENTRIES = 32,
    parameter  int AW      = 4,
    parameter  int CTXW    = 8,
    parameter  int ITW     = 8,
    parameter  int NW      = 3,
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]           ent_valid,
    input  logic [ENTRIES-1:0][AW-1:0]   ent_addr,
    input  logic [ENTRIES-1:0][NW-1:0]   ent_names,
    input  logic [ENTRIES-1:0][CTXW-1:0] ent_ctx,
    input  logic [ENTRIES-1:0][ITW-1:0]  ent_iter,
    input  logic [AW-1:0]                key_addr,
    input  logic [NW-1:0]                key_names,
    input  logic [CTXW-1:0]              key_ctx,
    input  logic [ITW-1:0]               key_iter,
    output logic                         hit,
    output logic [IW-1:0]                hit_idx,
    output logic                         free_avail,
    output logic [IW-1:0]                free_idx
);
    logic [ENTRIES-1:0] pre_hit;
    logic [ENTRIES-1:0] full_hit;

    // Per-entry comparators: name-count prefilter, then full tag.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign pre_hit[g]  = ent_valid[g] && (ent_addr[g] == key_addr)
                             && (ent_names[g] == key_names);
        assign full_hit[g] = pre_hit[g] && (ent_ctx[g] == key_ctx)
                             && (ent_iter[g] == key_iter);
    end

    // Priority encoders: lowest matching entry and lowest free entry.
    always_comb begin
        hit        = 1'b0;
        hit_idx    = '0;
        free_avail = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (full_hit[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!ent_valid[i]) begin
                free_avail = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tmu_match_unit.sv
// Token matching unit. Accepts one token per cycle, looks it up in the
// associative waiting store and either bypasses it, merges it into a waiting
// set, opens a new set, or stalls it when the store is full. A completed set
// leaves as a registered packet one cycle after its last token is accepted.
// A duplicate port within a set halts input until reset.
// Assumes: tok_port is below PORTS; the packet consumer never stalls.
module tmu_match_unit #(
    parameter  int ENTRIES = 32,
    parameter  int PORTS   = 4,
    parameter  int AW      = 4,
    parameter  int CTXW    = 8,
    parameter  int ITW     = 8,
    parameter  int NW      = 3,
    parameter  int DW      = 16,
    localparam int PW      = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int CW      = $clog2(PORTS + 1),
    localparam int IW      = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [CW-1:0]         cfg_need,
    input  logic [CW-1:0]         cfg_const,
    input  logic                  tok_valid,
    output logic                  tok_ready,
    input  logic [AW-1:0]         tok_addr,
    input  logic [PW-1:0]         tok_port,
    input  logic [CTXW-1:0]       tok_ctx,
    input  logic [ITW-1:0]        tok_iter,
    input  logic [NW-1:0]         tok_names,
    input  logic [DW-1:0]         tok_data,
    output logic                  pkt_valid,
    output logic [AW-1:0]         pkt_addr,
    output logic [CTXW-1:0]       pkt_ctx,
    output logic [ITW-1:0]        pkt_iter,
    output logic [PORTS-1:0]      pkt_mask,
    output logic [PORTS*DW-1:0]   pkt_data,
    output logic                  store_stall,
    output logic                  halted
);
    import tmu_pkg::*;

    // Waiting store.
    logic [ENTRIES-1:0]                       ev_q;
    logic [ENTRIES-1:0][AW-1:0]               ea_q;
    logic [ENTRIES-1:0][NW-1:0]               en_q;
    logic [ENTRIES-1:0][CTXW-1:0]             ec_q;
    logic [ENTRIES-1:0][ITW-1:0]              ei_q;
    logic [ENTRIES-1:0][CW-1:0]               cnt_q;
    logic [ENTRIES-1:0][PORTS-1:0]            mask_q;
    logic [ENTRIES-1:0][PORTS-1:0][DW-1:0]    data_q;

    logic                          halted_q;
    logic                          pv_q;
    logic [AW-1:0]                 pa_q;
    logic [CTXW-1:0]               pc_q;
    logic [ITW-1:0]                pi_q;
    logic [PORTS-1:0]              pm_q;
    logic [PORTS-1:0][DW-1:0]      pd_q;

    logic [CW-1:0]                 need;
    logic [CW-1:0]                 cst;
    logic                          hit;
    logic [IW-1:0]                 hit_idx;
    logic                          free_avail;
    logic [IW-1:0]                 free_idx;

    logic                          solo;
    logic                          dup;
    logic                          finish;
    logic                          fire;
    disp_e                         disp;
    logic [PORTS-1:0]              port_bit;
    logic [PORTS-1:0][DW-1:0]      fresh_data;
    logic [PORTS-1:0][DW-1:0]      merged_data;
    logic [PORTS-1:0]              merged_mask;

    tmu_cfg_table #(
        .AW (AW),
        .CW (CW)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_need  (cfg_need),
        .wr_const (cfg_const),
        .rd_addr  (tok_addr),
        .rd_need  (need),
        .rd_const (cst)
    );

    tmu_cam_search #(
        .ENTRIES (ENTRIES),
        .AW      (AW),
        .CTXW    (CTXW),
        .ITW     (ITW),
        .NW      (NW)
    ) search_i (
        .ent_valid  (ev_q),
        .ent_addr   (ea_q),
        .ent_names  (en_q),
        .ent_ctx    (ec_q),
        .ent_iter   (ei_q),
        .key_addr   (tok_addr),
        .key_names  (tok_names),
        .key_ctx    (tok_ctx),
        .key_iter   (tok_iter),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_avail (free_avail),
        .free_idx   (free_idx)
    );

    // Operand assembly: one-hot port bit, fresh slot vector, merged set.
    always_comb begin
        port_bit              = {{(PORTS-1){1'b0}}, 1'b1} << tok_port;
        fresh_data            = '0;
        fresh_data[tok_port]  = tok_data;
        merged_data           = data_q[hit_idx];
        merged_data[tok_port] = tok_data;
        merged_mask           = mask_q[hit_idx] | port_bit;
    end

    // Completion arithmetic: solo enable, duplicate port, set completion.
    always_comb begin
        solo   = ({1'b0, cst} + (CW+1)'(1)) >= {1'b0, need};
        dup    = hit && ((mask_q[hit_idx] & port_bit) != '0);
        finish = ({1'b0, cnt_q[hit_idx]} + {1'b0, cst} + (CW+1)'(1))
                 >= {1'b0, need};
    end

    // Disposition of the token at the input.
    always_comb begin
        if (solo)            disp = DISP_BYPASS;
        else if (hit)        disp = DISP_MERGE;
        else if (free_avail) disp = DISP_ALLOC;
        else                 disp = DISP_STALL;
    end

    assign tok_ready   = !halted_q && (disp != DISP_STALL);
    assign store_stall = tok_valid && !halted_q && (disp == DISP_STALL);
    assign fire        = tok_valid && tok_ready;

    // Store update: open, extend or retire entries; latch the halt error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q     <= '0;
            ea_q     <= '0;
            en_q     <= '0;
            ec_q     <= '0;
            ei_q     <= '0;
            cnt_q    <= '0;
            mask_q   <= '0;
            data_q   <= '0;
            halted_q <= 1'b0;
        end else if (fire) begin
            case (disp)
                DISP_MERGE: begin
                    if (dup) begin
                        halted_q <= 1'b1;
                    end else if (finish) begin
                        ev_q[hit_idx] <= 1'b0;
                    end else begin
                        cnt_q[hit_idx]  <= cnt_q[hit_idx] + CW'(1);
                        mask_q[hit_idx] <= merged_mask;
                        data_q[hit_idx] <= merged_data;
                    end
                end
                DISP_ALLOC: begin
                    ev_q[free_idx]   <= 1'b1;
                    ea_q[free_idx]   <= tok_addr;
                    en_q[free_idx]   <= tok_names;
                    ec_q[free_idx]   <= tok_ctx;
                    ei_q[free_idx]   <= tok_iter;
                    cnt_q[free_idx]  <= CW'(1);
                    mask_q[free_idx] <= port_bit;
                    data_q[free_idx] <= fresh_data;
                end
                default: ;
            endcase
        end
    end

    // Packet register: bypassed tokens and completed sets, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q <= 1'b0;
            pa_q <= '0;
            pc_q <= '0;
            pi_q <= '0;
            pm_q <= '0;
            pd_q <= '0;
        end else begin
            pv_q <= 1'b0;
            if (fire && (disp == DISP_BYPASS)) begin
                pv_q <= 1'b1;
                pa_q <= tok_addr;
                pc_q <= tok_ctx;
                pi_q <= tok_iter;
                pm_q <= port_bit;
                pd_q <= fresh_data;
            end else if (fire && (disp == DISP_MERGE) && !dup && finish) begin
                pv_q <= 1'b1;
                pa_q <= tok_addr;
                pc_q <= tok_ctx;
                pi_q <= tok_iter;
                pm_q <= merged_mask;
                pd_q <= merged_data;
            end
        end
    end

    assign pkt_valid = pv_q;
    assign pkt_addr  = pa_q;
    assign pkt_ctx   = pc_q;
    assign pkt_iter  = pi_q;
    assign pkt_mask  = pm_q;
    assign pkt_data  = pd_q;
    assign halted    = halted_q;
endmodule

// File: rtl/tmu_match_unit_chk.sv
// Property checker for the token matching unit, attached by bind.
// Assumes: it sees the top-level ports only.
module tmu_match_unit_chk #(
    parameter int PORTS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_valid,
    input logic             tok_ready,
    input logic             store_stall,
    input logic             halted,
    input logic             pkt_valid,
    input logic [PORTS-1:0] pkt_mask
);
    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7
    halt_closes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !tok_ready);

    // R8
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_stall |-> !tok_ready);

    // R3
    pkt_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(tok_valid && tok_ready));

    // R5
    pkt_mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_mask != '0));
endmodule

bind tmu_match_unit tmu_match_unit_chk #(.PORTS(PORTS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_valid   (tok_valid),
    .tok_ready   (tok_ready),
    .store_stall (store_stall),
    .halted      (halted),
    .pkt_valid   (pkt_valid),
    .pkt_mask    (pkt_mask)
);

// File: tb/tmu_match_unit_tb_top.sv
// Scoreboard bench: driver tasks queue expected packets, a negedge monitor
// pops and compares them as packets appear.
module tmu_match_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 4;
    localparam int PORTS   = 4;
    localparam int AW      = 4;
    localparam int CTXW    = 8;
    localparam int ITW     = 8;
    localparam int NW      = 3;
    localparam int DW      = 16;
    localparam int PW      = 2;
    localparam int CW      = 3;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic                rst_n = 1'b0;
    logic                cfg_we = 1'b0;
    logic [AW-1:0]       cfg_addr = '0;
    logic [CW-1:0]       cfg_need = '0;
    logic [CW-1:0]       cfg_const = '0;
    logic                tok_valid = 1'b0;
    logic                tok_ready;
    logic [AW-1:0]       tok_addr = '0;
    logic [PW-1:0]       tok_port = '0;
    logic [CTXW-1:0]     tok_ctx = '0;
    logic [ITW-1:0]      tok_iter = '0;
    logic [NW-1:0]       tok_names = '0;
    logic [DW-1:0]       tok_data = '0;
    logic                pkt_valid;
    logic [AW-1:0]       pkt_addr;
    logic [CTXW-1:0]     pkt_ctx;
    logic [ITW-1:0]      pkt_iter;
    logic [PORTS-1:0]    pkt_mask;
    logic [PORTS*DW-1:0] pkt_data;
    logic                store_stall;
    logic                halted;

    tmu_match_unit #(
        .ENTRIES (ENTRIES), .PORTS (PORTS), .AW (AW), .CTXW (CTXW),
        .ITW (ITW), .NW (NW), .DW (DW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_need (cfg_need),
        .cfg_const (cfg_const),
        .tok_valid (tok_valid), .tok_ready (tok_ready), .tok_addr (tok_addr),
        .tok_port (tok_port), .tok_ctx (tok_ctx), .tok_iter (tok_iter),
        .tok_names (tok_names), .tok_data (tok_data),
        .pkt_valid (pkt_valid), .pkt_addr (pkt_addr), .pkt_ctx (pkt_ctx),
        .pkt_iter (pkt_iter), .pkt_mask (pkt_mask), .pkt_data (pkt_data),
        .store_stall (store_stall), .halted (halted)
    );

    typedef struct {
        string               req;
        logic [AW-1:0]       addr;
        logic [CTXW-1:0]     ctx;
        logic [ITW-1:0]      iter;
        logic [PORTS-1:0]    mask;
        logic [PORTS*DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic last_ready;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [PORTS*DW-1:0] sl(input int p, input logic [DW-1:0] v);
        return (PORTS*DW)'(v) << (p * DW);
    endfunction

    task automatic cfg(input int a, input int need, input int cst);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_need = CW'(need); cfg_const = CW'(cst);
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic send(input int a, input int p, input int c, input int it,
                        input int nm, input int d);
        @(negedge clk);
        tok_valid = 1'b1; tok_addr = AW'(a); tok_port = PW'(p);
        tok_ctx = CTXW'(c); tok_iter = ITW'(it); tok_names = NW'(nm);
        tok_data = DW'(d);
        #1 last_ready = tok_ready;
        @(posedge clk);
        #1 tok_valid = 1'b0;
    endtask

    task automatic expect_pkt(input string req, input int a, input int c,
                              input int it, input int m,
                              input logic [PORTS*DW-1:0] d);
        exp_t e;
        e.req = req; e.addr = AW'(a); e.ctx = CTXW'(c); e.iter = ITW'(it);
        e.mask = PORTS'(m); e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic idle_chk(input string req);
        @(negedge clk);
        chk(pkt_valid == 1'b0, req, "no packet expected", 64'(pkt_valid), 64'd0);
    endtask

    // Monitor: compare every packet against the head of the scoreboard.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && pkt_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected packet mask", 64'(pkt_mask), 64'd0);
            end else begin
                e = exp_q.pop_front();
                checks++;
                if (pkt_addr != e.addr || pkt_ctx != e.ctx || pkt_iter != e.iter
                    || pkt_mask != e.mask || pkt_data != e.data) begin
                    fails++;
                    $display("FAIL %s packet actual=a%0h/c%0h/i%0h/m%0h/d%0h expected=a%0h/c%0h/i%0h/m%0h/d%0h",
                             e.req, pkt_addr, pkt_ctx, pkt_iter, pkt_mask, pkt_data,
                             e.addr, e.ctx, e.iter, e.mask, e.data);
                end
            end
        end
    end

    task automatic reset_chk();
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R1", "pkt_valid after reset", 64'(pkt_valid), 64'd0);
        chk(halted == 1'b0, "R1", "halted after reset", 64'(halted), 64'd0);
        chk(store_stall == 1'b0, "R1", "store_stall after reset", 64'(store_stall), 64'd0);
        chk(tok_ready == 1'b1, "R1", "tok_ready after reset", 64'(tok_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        reset_chk();

        // R1: untouched table address behaves as a single-token instruction
        expect_pkt("R1", 9, 0, 0, 4'b0100, sl(2, 16'h0909));
        send(9, 2, 0, 0, 1, 16'h0909);

        cfg(1, 2, 0);
        cfg(2, 3, 1);
        cfg(3, 1, 0);
        cfg(4, 2, 1);
        cfg(5, 3, 0);

        // R4: single-token instruction and constant-assisted single token
        expect_pkt("R4", 3, 2, 1, 4'b0001, sl(0, 16'h1111));
        send(3, 0, 2, 1, 1, 16'h1111);
        expect_pkt("R4", 4, 2, 1, 4'b0010, sl(1, 16'h2222));
        send(4, 1, 2, 1, 1, 16'h2222);

        // R2 / R5: different iterations stay apart; slots land by port
        send(1, 1, 5, 1, 1, 16'hA001);
        send(1, 0, 5, 2, 1, 16'hB002);
        idle_chk("R2");
        expect_pkt("R5", 1, 5, 1, 4'b0011, sl(0, 16'hA000) | sl(1, 16'hA001));
        send(1, 0, 5, 1, 1, 16'hA000);
        expect_pkt("R2", 1, 5, 2, 4'b0011, sl(0, 16'hB002) | sl(1, 16'hB003));
        send(1, 1, 5, 2, 1, 16'hB003);

        // R3: one constant plus two tokens
        send(2, 2, 6, 3, 2, 16'hC002);
        idle_chk("R3");
        expect_pkt("R3", 2, 6, 3, 4'b0101, sl(0, 16'hC000) | sl(2, 16'hC002));
        send(2, 0, 6, 3, 2, 16'hC000);

        // R6: same context and iteration, different name count
        send(1, 0, 7, 1, 1, 16'hD100);
        send(1, 1, 7, 1, 2, 16'hD201);
        idle_chk("R6");
        expect_pkt("R6", 1, 7, 1, 4'b0011, sl(0, 16'hD100) | sl(1, 16'hD101));
        send(1, 1, 7, 1, 1, 16'hD101);
        expect_pkt("R6", 1, 7, 1, 4'b0011, sl(0, 16'hD200) | sl(1, 16'hD201));
        send(1, 0, 7, 1, 2, 16'hD200);

        // R9: rewrite table entry, then restore
        cfg(1, 1, 0);
        expect_pkt("R9", 1, 8, 0, 4'b1000, sl(3, 16'hE003));
        send(1, 3, 8, 0, 1, 16'hE003);
        cfg(1, 2, 0);

        // R8: fill all four entries with pending three-token sets
        for (int k = 0; k < 4; k++) send(5, 0, 1, 10 + k, 1, 16'h5000 + k);
        idle_chk("R8");
        @(negedge clk);
        tok_valid = 1'b1; tok_addr = 4'd5; tok_port = 2'd0; tok_ctx = 8'd1;
        tok_iter = 8'd14; tok_names = 3'd1; tok_data = 16'h5004;
        #1;
        chk(tok_ready == 1'b0, "R8", "tok_ready with full store", 64'(tok_ready), 64'd0);
        chk(store_stall == 1'b1, "R8", "store_stall with full store", 64'(store_stall), 64'd1);
        tok_valid = 1'b0;
        expect_pkt("R8", 3, 0, 0, 4'b0001, sl(0, 16'h3333));
        send(3, 0, 0, 0, 1, 16'h3333);
        chk(last_ready == 1'b1, "R8", "bypass accepted while full", 64'(last_ready), 64'd1);
        send(5, 1, 1, 10, 1, 16'h5101);
        chk(last_ready == 1'b1, "R8", "merge accepted while full", 64'(last_ready), 64'd1);
        expect_pkt("R3", 5, 1, 10, 4'b0111,
                   sl(0, 16'h5000) | sl(1, 16'h5101) | sl(2, 16'h5202));
        send(5, 2, 1, 10, 1, 16'h5202);
        send(5, 0, 1, 14, 1, 16'h5004);
        chk(last_ready == 1'b1, "R3", "freed entry reused", 64'(last_ready), 64'd1);
        idle_chk("R3");

        // R7: duplicate port in a waiting set
        send(5, 0, 1, 11, 1, 16'hDEAD);
        @(negedge clk);
        chk(halted == 1'b1, "R7", "halted after duplicate", 64'(halted), 64'd1);
        chk(pkt_valid == 1'b0, "R7", "no packet from duplicate", 64'(pkt_valid), 64'd0);
        tok_valid = 1'b1; tok_addr = 4'd3; tok_port = 2'd0;
        #1;
        chk(tok_ready == 1'b0, "R7", "tok_ready while halted", 64'(tok_ready), 64'd0);
        tok_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk(halted == 1'b1, "R7", "halt holds", 64'(halted), 64'd1);

        // R1: reset clears halt and store
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        reset_chk();
        cfg(1, 2, 0);
        send(1, 2, 3, 3, 1, 16'h7002);
        expect_pkt("R1", 1, 3, 3, 4'b1100, sl(2, 16'h7002) | sl(3, 16'h7003));
        send(1, 3, 3, 3, 1, 16'h7003);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "packets still pending", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule